// File: doc/BRIEF.md
# Three-Wire Serial Bus Master

This block is the host side of a synchronous serial link that uses three wires: a chip-enable strobe, a serial clock, and one data line whose direction can change. A local client places a request on a simple command interface. The request holds a 7-bit register address, a direction flag and a byte count. The block then runs the whole transaction without further help. It raises chip enable and waits a setup time. It shifts out a command byte that carries the address and the direction flag. After that it either streams data bytes out from the client or turns the data line around and streams bytes in to the client. All of these bytes fall inside one chip-enable window.

A single-register access is a request with a byte count of one. A burst is the same request with a larger count. The bit period comes from two parameters counted in system clock cycles: a chip-enable setup time and a half-period that applies to both the high and the low phase of the serial clock. Write bytes are pulled from the client one at a time through a take strobe. Read bytes are handed to the client one at a time through a valid strobe.

Top module: `tws_master`

## Requirements
- R1: After reset, chip enable, serial clock, data output enable, busy and done are all low.
- R2: A request is accepted only in a cycle where busy is low. A request held up while a transaction runs starts no new chip-enable window and does not change the transaction in progress.
- R3: The first byte of every transaction is the command byte. It holds the address in bits 7..1 and the direction flag in bit 0, where 1 means read and 0 means write. It is sent least-significant bit first.
- R4: Chip enable is high for exactly SETUP_CYC + HALF_CYC cycles before the first rising edge of the serial clock.
- R5: The serial clock is low whenever chip enable is low. Inside a window, every high phase and every low phase between two rising edges lasts exactly HALF_CYC cycles.
- R6: On a write, req_len + 1 data bytes follow the command byte, each sent least-significant bit first. Each byte is the value of wr_data at the moment it is captured. wr_take pulses for one cycle just after each capture, so there are req_len + 1 pulses in all.
- R7: On a read, sio_in is sampled at the end of each low phase, just before the serial clock rises. Bits arrive least-significant first. Each completed byte appears on rd_data together with a one-cycle rd_valid pulse, req_len + 1 times in all.
- R8: The data output enable is high for every command bit and every write bit. It drops as the serial clock falls after the last command bit of a read, which is at least one cycle before the first read sample, and it stays low for every read bit.
- R9: A window holds exactly 8 × (req_len + 2) rising edges of the serial clock.
- R10: After the last falling edge of the serial clock, chip enable stays high for HALF_CYC cycles and then falls. done is high for exactly one cycle, which is the first cycle with chip enable low, and busy goes low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while busy is low |
| req_addr | input | 7 | Register address placed in command bits 7..1 |
| req_read | input | 1 | 1 selects a read, 0 selects a write |
| req_len | input | LEN_W | Number of data bytes minus one |
| wr_data | input | 8 | Next byte to send on a write |
| wr_take | output | 1 | One-cycle pulse after wr_data has been captured |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse after chip enable falls |
| ce | output | 1 | Chip enable to the serial device |
| sck | output | 1 | Serial clock, idles low |
| sio_out | output | 1 | Serial data driven toward the device |
| sio_oe | output | 1 | Output enable for sio_out |
| sio_in | input | 1 | Serial data returned by the device |

## Verification
A wrong phase or byte counter shows on the wire before the window closes. The count of clock edges per window comes out wrong, or chip enable falls at the wrong byte, or wr_take and rd_valid give the wrong number of pulses. All of this appears by the done pulse of that same transaction. A broken half-period or setup timer shows up as a wrong run length at the very next clock edge. A direction error shows as the output enable being high at a read sample, or as read bytes that are shifted or swapped. Both appear within the first data byte that follows the command.

// File: rtl/tws_pkg.sv
`timescale 1ns/1ps
package tws_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = BYTE_W - 1;
    localparam int BITIDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } tws_state_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_WR,
        PH_RD
    } tws_phase_e;

    // Command byte layout: address in the upper bits, direction in bit 0.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rd;
    } tws_cmd_t;

    function automatic tws_cmd_t make_cmd(input logic [ADDR_W-1:0] a, input logic r);
        tws_cmd_t c;
        c.addr = a;
        c.rd   = r;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tws_timer.sv
`timescale 1ns/1ps
module tws_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] cnt;

    // Counts down to zero and holds there. A phase loaded with N-1 lasts N cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/tws_shreg.sv
`timescale 1ns/1ps
module tws_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    // One register serves both directions: bit 0 leaves first, new bits enter at the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {sin, q[W-1:1]};
        end
    end

endmodule

// File: rtl/tws_ctrl.sv
`timescale 1ns/1ps
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int SETUP_CYC = 800,
    parameter int HALF_CYC  = 200,
    parameter int LEN_W     = 5,
    parameter int TW        = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              tmr_exp,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    input  logic [BYTE_W-1:0] sh_q,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_val,
    output logic              sh_shift,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              wr_take,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done,
    output logic              ce,
    output logic              sck,
    output logic              sio_oe
);

    localparam logic [TW-1:0]       SETUP_LD = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0]       HALF_LD  = TW'(HALF_CYC - 1);
    localparam logic [BITIDX_W-1:0] LAST_BIT = BITIDX_W'(BYTE_W - 1);

    tws_state_e           state, state_n;
    tws_phase_e           phase;
    logic [BITIDX_W-1:0]  bitcnt;
    logic [LEN_W-1:0]     bleft;
    logic                 rd_q;
    logic                 accept;
    logic                 byte_end;
    logic                 last_byte;
    logic                 need_wr;
    tws_cmd_t             cmd_w;

    assign cmd_w     = make_cmd(req_addr, req_read);
    assign last_byte = (phase != PH_CMD) && (bleft == '0);
    assign need_wr   = (phase == PH_CMD) ? !rd_q : ((phase == PH_WR) && !last_byte);
    assign busy      = (state != ST_IDLE);

    always_comb begin
        state_n  = state;
        tmr_load = 1'b0;
        tmr_val  = HALF_LD;
        sh_load  = 1'b0;
        sh_val   = wr_data;
        sh_shift = 1'b0;
        accept   = 1'b0;
        byte_end = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    state_n  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                    sh_load  = 1'b1;
                    sh_val   = cmd_w;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_n  = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_exp) begin
                    state_n  = ST_HIGH;
                    tmr_load = 1'b1;
                    sh_shift = (phase == PH_RD);
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (bitcnt == LAST_BIT) begin
                        byte_end = 1'b1;
                        state_n  = last_byte ? ST_TAIL : ST_LOW;
                        sh_load  = need_wr;
                    end else begin
                        state_n  = ST_LOW;
                        sh_shift = (phase != PH_RD);
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_exp) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_CMD;
            bitcnt   <= '0;
            bleft    <= '0;
            rd_q     <= 1'b0;
            ce       <= 1'b0;
            sck      <= 1'b0;
            sio_oe   <= 1'b0;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            wr_take  <= 1'b0;
            rd_data  <= '0;
        end else begin
            state    <= state_n;
            done     <= 1'b0;
            rd_valid <= 1'b0;
            wr_take  <= sh_load && !accept;
            if (accept) begin
                ce     <= 1'b1;
                sio_oe <= 1'b1;
                phase  <= PH_CMD;
                bitcnt <= '0;
                bleft  <= req_len;
                rd_q   <= req_read;
            end
            if (state == ST_LOW && tmr_exp) begin
                sck <= 1'b1;
            end
            if (state == ST_HIGH && tmr_exp) begin
                sck    <= 1'b0;
                bitcnt <= bitcnt + 1'b1;
                if (byte_end) begin
                    if (phase == PH_CMD) begin
                        phase <= rd_q ? PH_RD : PH_WR;
                        if (rd_q) begin
                            sio_oe <= 1'b0;
                        end
                    end else begin
                        if (bleft != '0) begin
                            bleft <= bleft - 1'b1;
                        end
                        if (phase == PH_RD) begin
                            rd_data  <= sh_q;
                            rd_valid <= 1'b1;
                        end
                    end
                end
            end
            if (state == ST_TAIL && tmr_exp) begin
                ce     <= 1'b0;
                sio_oe <= 1'b0;
                done   <= 1'b1;
            end
        end
    end

    AST_OE_BEFORE_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW && tmr_exp && phase == PH_RD) |-> (!sio_oe && $past(!sio_oe))); // R8

    AST_TAIL_ON_BYTE_EDGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAIL) |-> (bitcnt == '0 && !sck)); // R9

    AST_CMD_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIGH && phase != PH_RD) |-> sio_oe); // R8

endmodule

// File: rtl/tws_master.sv
`timescale 1ns/1ps
module tws_master
    import tws_pkg::*;
#(
    parameter int SETUP_CYC = 800,
    parameter int HALF_CYC  = 200,
    parameter int LEN_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [6:0]       req_addr,
    input  logic             req_read,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             done,
    output logic             ce,
    output logic             sck,
    output logic             sio_out,
    output logic             sio_oe,
    input  logic             sio_in
);

    localparam int TMAX = max2(SETUP_CYC, HALF_CYC);
    localparam int TW   = $clog2(TMAX + 1);

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;
    logic              sh_load;
    logic [BYTE_W-1:0] sh_val;
    logic              sh_shift;
    logic [BYTE_W-1:0] sh_q;

    tws_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    tws_shreg #(.W(BYTE_W)) u_shreg (
        .clk      (clk),
        .rst      (rst),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .sin      (sio_in),
        .q        (sh_q)
    );

    tws_ctrl #(
        .SETUP_CYC (SETUP_CYC),
        .HALF_CYC  (HALF_CYC),
        .LEN_W     (LEN_W),
        .TW        (TW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_read  (req_read),
        .req_len   (req_len),
        .tmr_exp   (tmr_exp),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .sh_q      (sh_q),
        .sh_load   (sh_load),
        .sh_val    (sh_val),
        .sh_shift  (sh_shift),
        .wr_data   (wr_data),
        .wr_take   (wr_take),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .busy      (busy),
        .done      (done),
        .ce        (ce),
        .sck       (sck),
        .sio_oe    (sio_oe)
    );

    assign sio_out = sh_q[0];

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !ce |-> !sck); // R5

    AST_CE_RISE_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (ce && !$past(ce)) |-> $past(req_valid && !busy)); // R2

    AST_DONE_AFTER_CE_FALL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!ce && $past(ce) && !busy)); // R10

    AST_READ_BYTE_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> !sio_oe); // R7

endmodule

// File: tb/tws_master_bench.sv
`timescale 1ns/1ps
module tws_master_bench;

    localparam int SETUP = 10;
    localparam int HALF  = 3;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [6:0]    req_addr = '0;
    logic          req_read = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic [7:0]    wr_data = '0;
    logic          wr_take;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          busy, done, ce, sck, sio_out, sio_oe;
    logic          sio_in = 1'b0;

    tws_master #(.SETUP_CYC(SETUP), .HALF_CYC(HALF), .LEN_W(LW)) u_tws_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_read(req_read), .req_len(req_len), .wr_data(wr_data),
        .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .ce(ce), .sck(sck), .sio_out(sio_out),
        .sio_oe(sio_oe), .sio_in(sio_in)
    );

    initial forever #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [7:0] wbytes [64];
    logic [7:0] rbytes [64];
    logic [7:0] wcap   [64];
    logic [7:0] rcap   [64];
    logic [7:0] cmd_cap;
    int nrise, low_run, high_run, setup_cnt, tail_run;
    int bad_low, bad_high, oe_bad, ce_rises, rcnt, take_cnt, done_cnt, k;
    logic p_ce = 1'b0, p_sck = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device model and wire monitor, sampled away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (ce && !p_ce) begin
                    ce_rises++;
                    nrise = 0; low_run = 1; high_run = 0;
                end else if (ce) begin
                    if (sck && !p_sck) begin
                        if (nrise == 0) setup_cnt = low_run;
                        else if (low_run != HALF) bad_low++;
                        high_run = 1;
                        if (nrise < 8) begin
                            cmd_cap[nrise] = sio_out;
                            if (!sio_oe) oe_bad++;
                        end else if (cmd_cap[0]) begin
                            if (sio_oe) oe_bad++;
                        end else begin
                            wcap[(nrise-8)/8][(nrise-8)%8] = sio_out;
                            if (!sio_oe) oe_bad++;
                        end
                        nrise++;
                    end else if (!sck && p_sck) begin
                        if (high_run != HALF) bad_high++;
                        low_run = 1;
                        if (nrise >= 8 && cmd_cap[0]) begin
                            k = nrise - 8;
                            sio_in = rbytes[(k/8) % 64][k%8];
                        end
                    end else if (sck) high_run++;
                    else low_run++;
                end
                if (!ce && p_ce) tail_run = low_run;
                if (rd_valid) begin
                    rcap[rcnt % 64] = rd_data;
                    rcnt++;
                end
                if (wr_take) begin
                    take_cnt++;
                    wr_data = wbytes[take_cnt % 64];
                end
                if (done) done_cnt++;
            end
            p_ce = ce; p_sck = sck;
        end
    end

    task automatic run_txn(input logic [6:0] a, input logic rd, input int lenm1, input bit inject);
        int n = lenm1 + 1;
        int base = ce_rises;
        int mism = 0;
        for (int i = 0; i < 64; i++) begin
            wbytes[i] = 8'($urandom);
            rbytes[i] = 8'($urandom);
            wcap[i] = '0; rcap[i] = '0;
        end
        @(negedge clk);
        rcnt = 0; take_cnt = 0; done_cnt = 0;
        bad_low = 0; bad_high = 0; oe_bad = 0; setup_cnt = -1; tail_run = -1;
        wr_data = wbytes[0];
        req_addr = a; req_read = rd; req_len = LW'(lenm1); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            repeat (20) @(negedge clk);
            req_addr = ~a; req_read = ~rd; req_len = '0; req_valid = 1'b1;
            repeat (4) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        @(negedge clk);
        check(cmd_cap == {a, rd}, "R3 command byte", cmd_cap, {a, rd});
        check(nrise == 8 * (n + 1), "R9 clock edges per window", nrise, 8 * (n + 1));
        check(setup_cnt == SETUP + HALF, "R4 setup cycles", setup_cnt, SETUP + HALF);
        check(bad_low == 0 && bad_high == 0, "R5 phase length errors", bad_low + bad_high, 0);
        check(tail_run == HALF, "R10 chip enable hold", tail_run, HALF);
        check(done_cnt == 1, "R10 done pulses", done_cnt, 1);
        check(!busy && !ce && !sck, "R10 idle after done", {busy, ce, sck}, 0);
        check(oe_bad == 0, "R8 output enable errors", oe_bad, 0);
        check(ce_rises - base == 1, "R2 windows per request", ce_rises - base, 1);
        if (rd) begin
            check(rcnt == n, "R7 read byte count", rcnt, n);
            for (int i = 0; i < n; i++) if (rcap[i] != rbytes[i]) mism++;
            check(mism == 0, "R7 read byte mismatches", mism, 0);
            check(take_cnt == 0, "R6 no take on read", take_cnt, 0);
        end else begin
            check(take_cnt == n, "R6 take pulses", take_cnt, n);
            for (int i = 0; i < n; i++) if (wcap[i] != wbytes[i]) mism++;
            check(mism == 0, "R6 write byte mismatches", mism, 0);
            check(rcnt == 0, "R7 no read strobe on write", rcnt, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!ce && !sck && !sio_oe && !busy && !done, "R1 reset state",
              {ce, sck, sio_oe, busy, done}, 0);
        run_txn(7'h00, 1'b0, 0, 1'b0);
        run_txn(7'h7F, 1'b1, 0, 1'b0);
        run_txn(7'h40, 1'b0, 31, 1'b0);
        run_txn(7'h15, 1'b1, 31, 1'b0);
        run_txn(7'h2A, 1'b0, 2, 1'b1);
        run_txn(7'h55, 1'b1, 3, 1'b1);
        for (int t = 0; t < 16; t++) begin
            run_txn(7'($urandom), 1'($urandom), int'($urandom_range(0, 9)), 1'($urandom));
        end
        repeat (10) @(negedge clk);
        check(!ce && !sck && !busy, "R5 idle clock low", {ce, sck, busy}, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule